// File: doc/BRIEF.md
# Alert Output Mapper with Release Hold

This block drives a few general-purpose alert outputs for a supply monitor. Each output watches a flat vector of event sources: comparator faults, control inputs and other general-purpose inputs, all already brought to the clock domain. A per-output mask picks which of them count for that output. Any picked source drives the output active in the same cycle. The output then holds its active level after the last picked source goes quiet. The hold lasts a number of prescaler ticks set by a per-output delay code.

A held alert can be dropped early in two ways: a strobe from the alert-response handshake, or a strobe raised when the event history is read or cleared. Either strobe drops the hold only on outputs that have no picked source active. Where a cause is still present the strobe does nothing, and the full hold still follows once the cause goes away. Each output has a polarity bit. The bus decoding and the pad drivers are outside this block.

Top module: `alert_map_dor`

## Requirements
- R1: An output is active while at least one source whose mask bit is 1 is active; a source whose mask bit is 0 has no effect on that output.
- R2: An output goes active in the same clock cycle in which one of its mapped sources becomes active, with no register in between.
- R3: A prescaler ticks once every DIV clocks, running freely from reset. After all mapped sources drop, the output stays active until code×UNIT ticks have passed, and releases on the clock after that.
- R4: With delay code 0, the output stays active for exactly one clock after its mapped sources drop.
- R5: A mapped source becoming active while the hold is counting reloads the full count, so the release is measured from the last activity.
- R6: A one-cycle alert-response strobe while no mapped source is active ends the hold; the output is inactive from the next clock.
- R7: A one-cycle history read/clear strobe while no mapped source is active ends the hold the same way as R6.
- R8: Either strobe while a mapped source is active has no effect: the output stays active and the full hold follows after the sources drop.
- R9: Polarity bit 0 gives an active-high output (active = 1); polarity bit 1 gives an active-low output (active = 0).
- R10: While reset is asserted, every output sits at its inactive level whatever the sources, and no hold survives reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Event sources, 1 = active |
| mask_i | input | N_OUT*N_SRC | Per-output source selection; bits [o*N_SRC +: N_SRC] belong to output o |
| code_i | input | N_OUT*DLY_W | Per-output hold code; bits [o*DLY_W +: DLY_W] belong to output o |
| pol_i | input | N_OUT | Per-output polarity, 1 = active low |
| ara_i | input | 1 | Alert-response strobe, one cycle |
| hist_i | input | 1 | History read/clear strobe, one cycle |
| alert_o | output | N_OUT | Alert outputs |

## Verification
The assertions assume every input is synchronous to the clock, free of unknown values, and stable around the rising edge. They also assume the delay code does not change in the same cycle as the source activity it is meant to load. The bench changes all inputs only at falling edges and holds reset for several cycles before releasing it. It changes masks and codes only while the affected sources are quiet, so each reload sees a settled code. The bench model follows the prescaler phase from reset, so hold lengths are predicted exactly even though release falls at different points within a tick period.

// File: rtl/amap_pkg.sv
package amap_pkg;

  // Number of prescaler ticks that a hold code stands for.
  function automatic int unsigned release_ticks(int unsigned code, int unsigned unit);
    return code * unit;
  endfunction

  // Inactive pad level for a given polarity select (1 = active low).
  function automatic logic idle_level(logic active_low);
    return active_low;
  endfunction

endpackage

// File: rtl/amap_prescaler.sv
module amap_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pcnt;

  assign tick = (pcnt == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R3: ticks never come back to back when the divider exceeds one
      a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/amap_channel.sv
module amap_channel #(
  parameter int N_SRC = 8,
  parameter int DLY_W = 3,
  parameter int UNIT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] mask,
  input  logic [DLY_W-1:0] code,
  input  logic             clr,
  output logic             active
);
  localparam int MAX_LOAD = ((2 ** DLY_W) - 1) * UNIT;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  logic             hit;
  logic             hold;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load;
  logic             expire;

  assign hit    = |(src & mask);
  assign load   = CNT_W'(amap_pkg::release_ticks(int'(code), UNIT));
  assign expire = hold && !hit && !clr && (cnt == '0);
  assign active = rst_n && (hit || hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
      cnt  <= '0;
    end else if (hit) begin
      hold <= 1'b1;
      cnt  <= load;
    end else if (clr) begin
      hold <= 1'b0;
      cnt  <= '0;
    end else if (hold) begin
      if (cnt == '0) hold <= 1'b0;
      else if (tick) cnt <= cnt - 1'b1;
    end
  end

  // R5: source activity always (re)arms the hold with the full count
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (hold && cnt == $past(load)));

  // R3: between ticks the remaining count does not move
  a_r3_count_still: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !hit && !clr && !tick && cnt != '0) |=> (hold && $stable(cnt)));

  // R3: a tick takes exactly one off the count
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !hit && !clr && tick && cnt != '0) |=> (hold && cnt == $past(cnt) - 1'b1));

  // R3, R4: an exhausted count releases on the following clock
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !hold);

  // R6, R7: a strobe with no cause ends the hold
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && clr) |=> !hold);

  // R8: a strobe while a cause is present leaves the hold armed
  a_r8_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> hold);

endmodule

// File: rtl/alert_map_dor.sv
module alert_map_dor #(
  parameter int N_OUT = 2,
  parameter int N_SRC = 8,
  parameter int DLY_W = 3,
  parameter int UNIT  = 2,
  parameter int DIV   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_i,
  input  logic [N_OUT*N_SRC-1:0] mask_i,
  input  logic [N_OUT*DLY_W-1:0] code_i,
  input  logic [N_OUT-1:0]       pol_i,
  input  logic                   ara_i,
  input  logic                   hist_i,
  output logic [N_OUT-1:0]       alert_o
);
  logic             tick;
  logic             clr;
  logic [N_OUT-1:0] active;

  assign clr = ara_i | hist_i;

  amap_prescaler #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      amap_channel #(.N_SRC(N_SRC), .DLY_W(DLY_W), .UNIT(UNIT)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .src    (src_i),
        .mask   (mask_i[o*N_SRC +: N_SRC]),
        .code   (code_i[o*DLY_W +: DLY_W]),
        .clr    (clr),
        .active (active[o])
      );
      assign alert_o[o] = active[o] ^ pol_i[o];

      // R10: held at the idle level throughout reset
      always_comb begin
        if (!rst_n) begin
          a_r10_reset_idle: assert (alert_o[o] == amap_pkg::idle_level(pol_i[o]));
        end
      end
    end
  endgenerate

endmodule

// File: tb/alert_map_dor_bench.sv
module alert_map_dor_bench;
  localparam int N_OUT = 2;
  localparam int N_SRC = 8;
  localparam int DLY_W = 3;
  localparam int UNIT  = 2;
  localparam int DIV   = 4;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [N_SRC-1:0]       src_i = '0;
  logic [N_OUT*N_SRC-1:0] mask_i = '1;
  logic [N_OUT*DLY_W-1:0] code_i = '0;
  logic [N_OUT-1:0]       pol_i = 2'b10;
  logic                   ara_i = 1'b0;
  logic                   hist_i = 1'b0;
  logic [N_OUT-1:0]       alert_o;

  int    n_run = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string phase = "R10 reset";

  // behavioural reference state
  int mpres = 0;
  int mhold[N_OUT];
  int mcnt[N_OUT];

  alert_map_dor #(.N_OUT(N_OUT), .N_SRC(N_SRC), .DLY_W(DLY_W), .UNIT(UNIT), .DIV(DIV)) u_alert_map_dor (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_i(mask_i), .code_i(code_i),
    .pol_i(pol_i), .ara_i(ara_i), .hist_i(hist_i), .alert_o(alert_o)
  );

  always #5 clk = ~clk;

  function automatic bit mapped(int o);
    return (src_i & mask_i[o*N_SRC +: N_SRC]) != 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mpres = 0;
      for (int o = 0; o < N_OUT; o++) begin mhold[o] = 0; mcnt[o] = 0; end
    end else begin
      bit tk;
      tk = (mpres == DIV - 1);
      for (int o = 0; o < N_OUT; o++) begin
        if (mapped(o)) begin
          mhold[o] = 1;
          mcnt[o] = int'(code_i[o*DLY_W +: DLY_W]) * UNIT;
        end else if (ara_i || hist_i) begin
          mhold[o] = 0; mcnt[o] = 0;
        end else if (mhold[o] != 0) begin
          if (mcnt[o] == 0) mhold[o] = 0;
          else if (tk) mcnt[o]--;
        end
      end
      mpres = tk ? 0 : mpres + 1;
    end
  end

  always @(negedge clk) begin
    #4;
    for (int o = 0; o < N_OUT; o++) begin
      bit act;
      logic expv;
      act  = rst_n && (mapped(o) || mhold[o] != 0);
      expv = logic'(act) ^ pol_i[o];
      n_run++;
      if (alert_o[o] !== expv) begin
        n_fail++;
        $display("FAIL %s out%0d cycle %0d: got %b expected %b", phase, o, cycles, alert_o[o], expv);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_src(logic [N_SRC-1:0] v, int len);
    @(negedge clk); src_i = v;
    idle(len);
    src_i = '0;
  endtask

  task automatic strobe(bit use_ara);
    @(negedge clk);
    if (use_ara) ara_i = 1'b1; else hist_i = 1'b1;
    @(negedge clk);
    ara_i = 1'b0; hist_i = 1'b0;
  endtask

  initial begin
    logic [7:0] lfsr;
    // R10: sources active during reset must not show
    src_i = 8'hFF;
    idle(4);
    src_i = '0;
    rst_n = 1'b1;
    idle(3);

    phase = "R1 mask selection";
    mask_i = {8'hF0, 8'h0F};
    code_i = '0;
    pulse_src(8'h20, 3); idle(3);
    pulse_src(8'h01, 3); idle(3);
    pulse_src(8'h81, 2); idle(3);

    phase = "R2 same-cycle assert";
    pulse_src(8'h04, 1); idle(2);
    pulse_src(8'h40, 1); idle(2);

    phase = "R4 code zero";
    pulse_src(8'h11, 2); idle(4);

    phase = "R9 polarity";
    pol_i = 2'b01;
    pulse_src(8'h22, 2); idle(4);
    pol_i = 2'b10;
    idle(1);

    phase = "R3 hold length";
    code_i = {3'd7, 3'd3};
    pulse_src(8'h11, 1); idle(70);
    idle(1); pulse_src(8'h11, 1); idle(70);
    idle(2); pulse_src(8'h02, 4); idle(40);

    phase = "R5 reload";
    pulse_src(8'h11, 1); idle(9);
    pulse_src(8'h11, 1); idle(20);
    pulse_src(8'h10, 1); idle(70);

    phase = "R6 response clear";
    pulse_src(8'h11, 1); idle(6);
    strobe(1'b1); idle(8);

    phase = "R7 history clear";
    pulse_src(8'h11, 1); idle(5);
    strobe(1'b0); idle(8);

    phase = "R8 clear blocked";
    @(negedge clk); src_i = 8'h01;
    idle(2);
    strobe(1'b1); strobe(1'b0);
    idle(2);
    src_i = '0;
    idle(70);
    // cause on one output only: the other clears
    pulse_src(8'h11, 1); idle(3);
    @(negedge clk); src_i = 8'h10;
    strobe(1'b1);
    src_i = '0;
    idle(70);

    phase = "R1 mixed traffic";
    lfsr = 8'hA5;
    code_i = {3'd2, 3'd1};
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      src_i  = (lfsr[2:0] == 3'd0) ? lfsr : 8'h00;
      ara_i  = (lfsr[7:4] == 4'hF);
      hist_i = (lfsr[7:4] == 4'h3);
    end
    @(negedge clk); src_i = '0; ara_i = 1'b0; hist_i = 1'b0;
    idle(40);

    phase = "R10 reset mid-hold";
    code_i = {3'd7, 3'd7};
    pulse_src(8'h11, 1); idle(3);
    rst_n = 1'b0; idle(3);
    rst_n = 1'b1; idle(5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule